// File: doc/BRIEF.md
# Edge-Triggered Timer Capture Channel

This block is one channel of a multi-channel counter array. It watches one external input pin. When the pin shows an edge of a selected kind, the channel copies the value of a shared free-running timer into its own capture register and sets an event flag. The rising edge and the falling edge can each be enabled on its own, so the channel can measure periods, pulse widths, duty cycles or phase offsets against the common timer.

The event flag is sticky. No hardware event clears it; software clears it with a one-cycle clear strobe. An interrupt request is raised while the flag is set and the channel's interrupt enable is on. Each new capture replaces the stored value, whether or not software has read the earlier one.

Top module: `cap_channel`

## Requirements
- R1: During and after synchronous active-low reset, with the pin held low, the capture value, the event flag and the interrupt request are all 0.
- R2: With rising capture enabled, a 0-to-1 change on the pin, driven before clock edge k, is seen through a two-flop synchronizer and compared with the previous synchronized sample. At clock edge k+2 the capture register loads the timer input value present at that edge.
- R3: With falling capture enabled, a 1-to-0 change on the pin captures with the same timing as R2.
- R4: With both enables set, every edge of either kind captures.
- R5: An edge whose kind is not enabled (including when both enables are 0) leaves the capture register and the event flag unchanged.
- R6: Every capture sets the event flag at the same clock edge that loads the capture register, and the flag stays set while no clear strobe arrives.
- R7: A clear strobe sampled at a clock edge with no capture clears the event flag at that edge.
- R8: When a clear strobe and a capture fall on the same clock edge, the event flag ends up set.
- R9: The interrupt request equals the interrupt enable ANDed with the event flag, with no added delay.
- R10: A later capture overwrites the stored value even when the flag was never cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| timer_i | input | 16 | Value of the shared free-running timer |
| pin_i | input | 1 | External input pin, asynchronous |
| rise_en_i | input | 1 | Capture on rising pin edges |
| fall_en_i | input | 1 | Capture on falling pin edges |
| irq_en_i | input | 1 | Let the event flag drive the interrupt request |
| flag_clr_i | input | 1 | One-cycle software clear of the event flag |
| cap_o | output | 16 | Stored capture value |
| flag_o | output | 1 | Sticky event flag |
| irq_o | output | 1 | Interrupt request |

## Verification
A capture and a software clear can land on the same clock edge. When they do, the flag must end set. The bench creates this collision directly: it drives a pin edge and then raises the clear strobe exactly two cycles later. It also lets the collision occur at random in long runs where the strobe is raised often. In both cases a reference model built from the stated latency predicts the flag, the capture value and the interrupt request for every cycle, and the outputs are compared against it.

// File: rtl/cap_pkg.sv
package cap_pkg;

    localparam int unsigned TIMER_W_DEF = 16;
    localparam int unsigned SYNC_STAGES_DEF = 2;

    // Qualified edge events seen by the capture store.
    typedef struct packed {
        logic rise;
        logic fall;
    } edge_ev_t;

endpackage

// File: rtl/cap_sync.sv
module cap_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);

    typedef struct packed {
        logic [STAGES-1:0] chain;
    } sync_st_t;

    sync_st_t st_d, st_q;

    generate
        if (STAGES == 1) begin : g_one
            always_comb begin
                st_d = st_q;
                st_d.chain[0] = async_i;
            end
        end else begin : g_many
            always_comb begin
                st_d = st_q;
                st_d.chain = {st_q.chain[STAGES-2:0], async_i};
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sync_o = st_q.chain[STAGES-1];

endmodule

// File: rtl/cap_edge_detect.sv
module cap_edge_detect
    import cap_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     sample_i,
    input  logic     rise_en_i,
    input  logic     fall_en_i,
    output edge_ev_t ev_o
);

    typedef struct packed {
        logic prev;
    } det_st_t;

    det_st_t st_d, st_q;
    edge_ev_t ev_raw;

    always_comb begin
        st_d = st_q;
        st_d.prev = sample_i;
        ev_raw.rise = sample_i & ~st_q.prev;
        ev_raw.fall = ~sample_i & st_q.prev;
        ev_o.rise = ev_raw.rise & rise_en_i;
        ev_o.fall = ev_raw.fall & fall_en_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R5: a disabled edge kind never produces an event
    a_r5_rise_gated: assert property (@(posedge clk) disable iff (!rst_n)
        !rise_en_i |-> !ev_o.rise);
    a_r5_fall_gated: assert property (@(posedge clk) disable iff (!rst_n)
        !fall_en_i |-> !ev_o.fall);

endmodule

// File: rtl/cap_store.sv
module cap_store
    import cap_pkg::*;
#(
    parameter int unsigned TIMER_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  edge_ev_t           ev_i,
    input  logic [TIMER_W-1:0] timer_i,
    input  logic               clr_i,
    output logic [TIMER_W-1:0] cap_o,
    output logic               flag_o
);

    typedef struct packed {
        logic [TIMER_W-1:0] cap;
        logic               flag;
    } store_st_t;

    store_st_t st_d, st_q;
    logic      fire;

    always_comb begin
        st_d = st_q;
        fire = ev_i.rise | ev_i.fall;
        if (fire) begin
            st_d.cap = timer_i;
        end
        // capture wins over a coincident clear
        if (fire) begin
            st_d.flag = 1'b1;
        end else if (clr_i) begin
            st_d.flag = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cap_o  = st_q.cap;
    assign flag_o = st_q.flag;

    // R2: the capture register holds the timer value from the capturing edge
    a_r2_loads_timer: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_i.rise | ev_i.fall) |=> cap_o == $past(timer_i));
    // R5: no event means the stored value is left alone
    a_r5_cap_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(ev_i.rise | ev_i.fall) |=> $stable(cap_o));
    // R6: flag is sticky without a clear
    a_r6_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_o && !clr_i) |=> flag_o);
    // R7: clear without capture drops the flag
    a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !(ev_i.rise | ev_i.fall)) |=> !flag_o);
    // R8: capture beats a coincident clear
    a_r8_capture_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && (ev_i.rise | ev_i.fall)) |=> flag_o);

endmodule

// File: rtl/cap_channel.sv
module cap_channel
    import cap_pkg::*;
#(
    parameter int unsigned TIMER_W     = TIMER_W_DEF,
    parameter int unsigned SYNC_STAGES = SYNC_STAGES_DEF
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [TIMER_W-1:0] timer_i,
    input  logic               pin_i,
    input  logic               rise_en_i,
    input  logic               fall_en_i,
    input  logic               irq_en_i,
    input  logic               flag_clr_i,
    output logic [TIMER_W-1:0] cap_o,
    output logic               flag_o,
    output logic               irq_o
);

    logic     pin_sync;
    edge_ev_t ev;

    cap_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (pin_i),
        .sync_o  (pin_sync)
    );

    cap_edge_detect u_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .sample_i  (pin_sync),
        .rise_en_i (rise_en_i),
        .fall_en_i (fall_en_i),
        .ev_o      (ev)
    );

    cap_store #(
        .TIMER_W (TIMER_W)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .ev_i    (ev),
        .timer_i (timer_i),
        .clr_i   (flag_clr_i),
        .cap_o   (cap_o),
        .flag_o  (flag_o)
    );

    assign irq_o = irq_en_i & flag_o;

    // R9: a request is never raised while interrupts are disabled
    a_r9_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en_i |-> !irq_o);
    // R1: the outputs are clear on the first cycle after reset
    a_r1_reset_state: assert property (@(posedge clk)
        !rst_n |=> (cap_o == '0 && !flag_o));

endmodule

// File: tb/tb_cap_channel.sv
module tb_cap_channel;

    localparam int unsigned TW = 16;
    localparam time CLK_PERIOD = 10ns;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [TW-1:0] timer_i;
    logic          pin_i, rise_en_i, fall_en_i, irq_en_i, flag_clr_i;
    logic [TW-1:0] cap_o;
    logic          flag_o, irq_o;

    int n_checks = 0;
    int n_fail   = 0;

    // reference model state
    logic          m1 = 0, m2 = 0, m3 = 0;
    logic [TW-1:0] exp_cap = '0;
    logic          exp_flag = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cap_channel dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .timer_i    (timer_i),
        .pin_i      (pin_i),
        .rise_en_i  (rise_en_i),
        .fall_en_i  (fall_en_i),
        .irq_en_i   (irq_en_i),
        .flag_clr_i (flag_clr_i),
        .cap_o      (cap_o),
        .flag_o     (flag_o),
        .irq_o      (irq_o)
    );

    function automatic logic exp_fire(logic cur, logic prev, logic re, logic fe);
        return (re && cur && !prev) || (fe && !cur && prev);
    endfunction

    task automatic check(string tag, logic [TW-1:0] act, logic [TW-1:0] expv);
        n_checks++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, expv, $time);
        end
    endtask

    // one clock: apply inputs at the falling edge, model the rising edge,
    // compare at the next falling edge
    task automatic cyc(string tag, logic p, logic re, logic fe, logic ie,
                       logic clr, logic [TW-1:0] t);
        logic fire;
        pin_i = p; rise_en_i = re; fall_en_i = fe; irq_en_i = ie;
        flag_clr_i = clr; timer_i = t;
        @(posedge clk);
        fire = exp_fire(m2, m3, re, fe);
        if (fire) exp_cap = t;
        exp_flag = fire ? 1'b1 : (clr ? 1'b0 : exp_flag);
        m3 = m2; m2 = m1; m1 = p;
        @(negedge clk);
        check({tag, " cap"}, cap_o, exp_cap);
        check({tag, " flag"}, {15'b0, flag_o}, {15'b0, exp_flag});
        check("R9 irq", {15'b0, irq_o}, {15'b0, ie & exp_flag});
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 150000);
        n_fail++;
        $display("FAIL watchdog: actual hang expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin : stim
        logic p;
        void'($urandom(32'd1234));
        rst_n = 0; pin_i = 0; rise_en_i = 1; fall_en_i = 1; irq_en_i = 1;
        flag_clr_i = 0; timer_i = 16'h5a5a;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        check("R1 cap", cap_o, '0);
        check("R1 flag", {15'b0, flag_o}, 16'h0);
        check("R1 irq", {15'b0, irq_o}, 16'h0);
        rst_n = 1;
        cyc("R1", 0, 1, 1, 1, 0, 16'h0001);

        // R2: rising only, pin rises
        cyc("R2", 1, 1, 0, 0, 0, 16'h1000);
        for (int i = 0; i < 4; i++) cyc("R2", 1, 1, 0, 0, 0, 16'h1001 + 16'(i));
        // R3 disabled falling edge first: R5
        cyc("R5", 0, 1, 0, 1, 0, 16'h2000);
        for (int i = 0; i < 4; i++) cyc("R5", 0, 1, 0, 1, 0, 16'h2001 + 16'(i));
        // R7: clear without capture
        cyc("R7", 0, 1, 0, 1, 1, 16'h2100);
        cyc("R7", 0, 1, 0, 1, 0, 16'h2101);
        // R3: falling only
        cyc("R3", 1, 0, 1, 1, 0, 16'h3000);
        for (int i = 0; i < 3; i++) cyc("R3", 1, 0, 1, 1, 0, 16'h3001 + 16'(i));
        cyc("R3", 0, 0, 1, 1, 0, 16'h3100);
        for (int i = 0; i < 4; i++) cyc("R3", 0, 0, 1, 1, 0, 16'h3101 + 16'(i));
        // R5: both disabled, toggling pin, after clear
        cyc("R7", 0, 0, 0, 1, 1, 16'h4000);
        for (int i = 0; i < 8; i++) cyc("R5", 1'(i), 0, 0, 1, 0, 16'h4001 + 16'(i));
        for (int i = 0; i < 3; i++) cyc("R5", 0, 0, 0, 1, 0, 16'h4100);
        // R4 and R10: both enabled, edges overwrite without clear
        for (int i = 0; i < 12; i++) cyc("R10", 1'(i / 3), 1, 1, 1, 0, 16'h5000 + 16'(i));
        for (int i = 0; i < 12; i++) cyc("R4", 1'((i / 3) % 2), 1, 1, 0, 0, 16'h5100 + 16'(i));
        // R8: clear lands exactly on the capture edge
        cyc("R8", 0, 1, 1, 1, 0, 16'h6000);
        cyc("R8", 1, 1, 1, 1, 0, 16'h6001);
        cyc("R8", 1, 1, 1, 1, 0, 16'h6002);
        cyc("R8", 1, 1, 1, 1, 1, 16'h6003);
        cyc("R8", 1, 1, 1, 1, 0, 16'h6004);
        // R6: flag stays set with no clear
        for (int i = 0; i < 5; i++) cyc("R6", 1, 1, 1, 1, 0, 16'h6100);

        // random mix, clear raised often so collisions with captures occur
        for (int i = 0; i < 3000; i++) begin
            p = ($urandom % 4) == 0 ? ~pin_i : pin_i;
            cyc("R6", p, 1'($urandom), 1'($urandom), 1'($urandom),
                ($urandom % 3) == 0, 16'($urandom));
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

endmodule